// File: doc/BRIEF.md
# Dual Programmable Timer/Counter

This peripheral holds two independent timer channels of parameterised width (32 bits by default) behind a plain word-addressed register bus. Each channel has three registers: a control word, a reload value and the live count. The count can run up or down, one step per clock. When it rolls past its end value, the channel either restarts from the reload value, giving a periodic tick, or stops and holds there, giving a one-shot.

On each rollover the channel sets a pending flag in its control word. Software clears that flag by writing a 1 to the same bit, so writing back a value just read acknowledges the event. The single interrupt line is high while any channel has its pending flag and its interrupt enable both set.

A channel that is enabled, counts up and has its interrupt enable clear serves as a free-running time base that can be read at any moment. Bits of the control word that this block does not act on still store and read back, so software can probe the access width and byte order.

Top module: `dual_timer`

## Requirements
- R1: After reset every register of both channels reads 0 and `irq` is 0.
- R2: Registers are decoded on word-aligned byte addresses: channel c has its control word at 0x10*c+0x0, its reload value at 0x10*c+0x4 and its count at 0x10*c+0x8. Offset 0xC of each channel and any address with `addr[1:0]` not zero read as 0, and writes to them are ignored. The count is read-only.
- R3: Control bit positions: 0 mode, 1 down, 2 output-enable, 3 capture, 4 reload, 5 preset, 6 interrupt enable, 7 run, 8 pending, 9 and 10 spare. Bits 0–7, 9 and 10 read back exactly as written. Bits 11 and above read 0.
- R4: While the preset bit (bit 5) is 1, the count takes the reload value on every clock, including a reload value written during that time, and no counting happens.
- R5: With run=1, preset=0 and down=0, the count rises by one each clock.
- R6: With run=1, preset=0 and down=1, the count falls by one each clock.
- R7: With run=0, the count holds its value.
- R8: With reload=1, a rollover (an up-count at all ones, or a down-count at 0) loads the reload value on that clock, and counting continues from there.
- R9: With reload=0, a rollover leaves the count at its end value (all ones or 0). The count then holds, the run bit stays 1, and no further rollover occurs until the preset bit is set or run is cleared.
- R10: A rollover sets the pending bit (bit 8) whatever the interrupt enable says. The interrupt enable only gates `irq`.
- R11: A control write with bit 8 set clears the pending bit. A control write with bit 8 clear leaves it unchanged. If a rollover happens on the same clock, the set wins.
- R12: `irq` is high exactly when at least one channel has both pending and interrupt enable set. One channel's events do not change the other channel's registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 5 | Byte address of the register access |
| wr_en | input | 1 | Write strobe, one clock per write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Interrupt request |

## Verification
The step assertions assume that no control write lands on the same clock they judge. They therefore compare the count with the control bits that were in force on the previous clock, never with a freshly written word. A write strobe lasts exactly one clock. The bench holds `wr_en` for one cycle and drives address and data only between edges, so each access is a single, clean bus transaction. Free-running checks are taken only after a preset has fixed the starting count, so every expected count is known.

// File: rtl/timer_pkg.sv
// Package: shared constants for the dual timer.
// Assumes: control word bit positions are fixed because software decodes them.
package timer_pkg;
    localparam int CB_MODE   = 0;
    localparam int CB_DOWN   = 1;
    localparam int CB_RELOAD = 4;
    localparam int CB_PRESET = 5;
    localparam int CB_IE     = 6;
    localparam int CB_RUN    = 7;
    localparam int CB_PEND   = 8;
    localparam int CTRL_BITS = 11;          // implemented control bits
    localparam int CH_LSB    = 4;           // address bit that selects the channel

    // Word index of a register inside one channel's block
    typedef enum logic [1:0] {
        RSEL_CTRL  = 2'd0,
        RSEL_RELD  = 2'd1,
        RSEL_COUNT = 2'd2,
        RSEL_NONE  = 2'd3
    } reg_sel_t;
endpackage

// File: rtl/timer_regdec.sv
// Module: timer_regdec
// Decodes a byte address into a channel index and a register selector, and
// turns the write strobe into per-channel control and reload write enables.
// Assumes: accesses are word aligned; misaligned or out-of-range addresses hit nothing.
module timer_regdec
    import timer_pkg::*;
#(
    parameter int NCH = 2,
    parameter int AW  = 5,
    localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [AW-1:0]  addr,
    input  logic           wr_en,
    output logic           hit,
    output logic [CW-1:0]  ch_idx,
    output reg_sel_t       rsel,
    output logic [NCH-1:0] ctrl_we,
    output logic [NCH-1:0] reld_we
);
    logic [AW-1:CH_LSB] ch_field;

    // Split the address into fields and qualify it
    always_comb begin
        ch_field = addr[AW-1:CH_LSB];
        ch_idx   = CW'(ch_field);
        rsel     = reg_sel_t'(addr[3:2]);
        hit      = (addr[1:0] == 2'b00) && (int'(ch_field) < NCH);
    end

    // One-hot write enables per channel
    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            ctrl_we[c] = wr_en && hit && (int'(ch_idx) == c) && (rsel == RSEL_CTRL);
            reld_we[c] = wr_en && hit && (int'(ch_idx) == c) && (rsel == RSEL_RELD);
        end
    end
endmodule

// File: rtl/timer_channel.sv
// Module: timer_channel
// One timer channel: control word with write-1-to-clear pending bit, reload
// register, and an up/down counter with preset, auto-reload and one-shot stop.
// Assumes: control and reload writes are single-cycle strobes from the decoder.
module timer_channel
    import timer_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ctrl_we,
    input  logic         reld_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] ctrl_o,
    output logic [W-1:0] reld_o,
    output logic [W-1:0] count_o,
    output logic         halt_o,
    output logic         irq_o
);
    localparam logic [W-1:0] TOP = '1;

    logic [CTRL_BITS-1:0] ctrl_q;
    logic                 pend_q;
    logic [W-1:0]         reld_q;
    logic [W-1:0]         cnt_q;
    logic                 halt_q;
    logic                 run, down, preset, reload, ie, roll;

    // Name the control fields
    always_comb begin
        run    = ctrl_q[CB_RUN];
        down   = ctrl_q[CB_DOWN];
        preset = ctrl_q[CB_PRESET];
        reload = ctrl_q[CB_RELOAD];
        ie     = ctrl_q[CB_IE];
    end

    // Detect a rollover on this clock
    always_comb begin
        roll = run && !preset && !halt_q && (down ? (cnt_q == '0) : (cnt_q == TOP));
    end

    // Control and reload registers; the pending bit is kept apart
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            reld_q <= '0;
        end else begin
            if (ctrl_we) begin
                ctrl_q         <= wdata[CTRL_BITS-1:0];
                ctrl_q[CB_PEND] <= 1'b0;
            end
            if (reld_we) reld_q <= wdata;
        end
    end

    // Pending flag: rollover sets it, a written 1 clears it, set wins
    always_ff @(posedge clk) begin
        if (!rst_n)                        pend_q <= 1'b0;
        else if (roll)                     pend_q <= 1'b1;
        else if (ctrl_we && wdata[CB_PEND]) pend_q <= 1'b0;
    end

    // Counter: preset, step, reload or hold at the end value
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt_q <= '0;
        else if (preset)            cnt_q <= reld_q;
        else if (roll && reload)    cnt_q <= reld_q;
        else if (run && !halt_q && !roll)
            cnt_q <= down ? cnt_q - 1'b1 : cnt_q + 1'b1;
    end

    // One-shot stop flag: set at rollover without reload, freed by preset or stop
    always_ff @(posedge clk) begin
        if (!rst_n)                 halt_q <= 1'b0;
        else if (preset || !run)    halt_q <= 1'b0;
        else if (roll && !reload)   halt_q <= 1'b1;
    end

    // Drive outputs
    always_comb begin
        ctrl_o          = '0;
        ctrl_o[CTRL_BITS-1:0] = ctrl_q;
        ctrl_o[CB_PEND] = pend_q;
        reld_o          = reld_q;
        count_o         = cnt_q;
        halt_o          = halt_q;
        irq_o           = pend_q && ie;
    end
endmodule

// File: rtl/dual_timer.sv
// Module: dual_timer (top)
// Two timer channels behind a word-addressed register bus with a combinational
// read mux and one interrupt line that ORs the enabled pending flags.
// Assumes: wr_en is a one-clock strobe; reads have no side effects.
module dual_timer
    import timer_pkg::*;
#(
    parameter int NCH = 2,
    parameter int W   = 32,
    localparam int CW = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int AW = CH_LSB + CW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          wr_en,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata,
    output logic          irq
);
    logic                     hit;
    logic [CW-1:0]            ch_idx;
    reg_sel_t                 rsel;
    logic [NCH-1:0]           ctrl_we, reld_we, ch_irq, ch_halt;
    logic [NCH-1:0][W-1:0]    ch_ctrl, ch_reld, ch_cnt;

    timer_regdec #(.NCH(NCH), .AW(AW)) u_dec (
        .addr(addr), .wr_en(wr_en), .hit(hit), .ch_idx(ch_idx),
        .rsel(rsel), .ctrl_we(ctrl_we), .reld_we(reld_we)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        timer_channel #(.W(W)) u_ch (
            .clk(clk), .rst_n(rst_n),
            .ctrl_we(ctrl_we[c]), .reld_we(reld_we[c]), .wdata(wdata),
            .ctrl_o(ch_ctrl[c]), .reld_o(ch_reld[c]), .count_o(ch_cnt[c]),
            .halt_o(ch_halt[c]), .irq_o(ch_irq[c])
        );
    end

    // Read mux over the selected channel's registers
    always_comb begin
        rdata = '0;
        if (hit) begin
            unique case (rsel)
                RSEL_CTRL:  rdata = ch_ctrl[ch_idx];
                RSEL_RELD:  rdata = ch_reld[ch_idx];
                RSEL_COUNT: rdata = ch_cnt[ch_idx];
                default:    rdata = '0;
            endcase
        end
    end

    // Combine channel interrupts
    always_comb irq = |ch_irq;
endmodule

// File: rtl/timer_checker.sv
// Module: timer_checker
// Temporal checks on the dual timer, bound to the top module.
// Assumes: control fields of the previous clock govern the current count.
module timer_checker
    import timer_pkg::*;
#(
    parameter int NCH = 2,
    parameter int W   = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  irq,
    input logic [NCH-1:0][W-1:0] ch_ctrl,
    input logic [NCH-1:0][W-1:0] ch_reld,
    input logic [NCH-1:0][W-1:0] ch_cnt,
    input logic [NCH-1:0]        ch_halt
);
    logic past_ok;
    logic [NCH-1:0] pend_v;

    // Mark that one clock since reset has passed
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // Gather pending bits
    always_comb for (int c = 0; c < NCH; c++) pend_v[c] = ch_ctrl[c][CB_PEND];

    AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_v == '0) |-> !irq); // R12

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        AST_PRESET_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
            (past_ok && $past(ch_ctrl[c][CB_PRESET])) |-> (ch_cnt[c] == $past(ch_reld[c]))); // R4
        AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (past_ok && $past(!ch_ctrl[c][CB_RUN] && !ch_ctrl[c][CB_PRESET])) |-> $stable(ch_cnt[c])); // R7
        AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
            (past_ok && $past(ch_ctrl[c][CB_RUN] && !ch_ctrl[c][CB_PRESET] && !ch_ctrl[c][CB_DOWN]
                              && !ch_halt[c] && (ch_cnt[c] != {W{1'b1}})))
            |-> (ch_cnt[c] == $past(ch_cnt[c]) + 1'b1)); // R5
        AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
            (past_ok && $past(ch_ctrl[c][CB_RUN] && !ch_ctrl[c][CB_PRESET] && ch_ctrl[c][CB_DOWN]
                              && !ch_halt[c] && (ch_cnt[c] != '0)))
            |-> (ch_cnt[c] == $past(ch_cnt[c]) - 1'b1)); // R6
        AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (past_ok && $past(ch_halt[c] && !ch_ctrl[c][CB_PRESET])) |-> $stable(ch_cnt[c])); // R9
        AST_PEND_FROM_RUN: assert property (@(posedge clk) disable iff (!rst_n)
            (past_ok && $rose(ch_ctrl[c][CB_PEND])) |-> $past(ch_ctrl[c][CB_RUN])); // R10
    end
endmodule

bind dual_timer timer_checker #(.NCH(NCH), .W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq(irq), .ch_ctrl(ch_ctrl),
    .ch_reld(ch_reld), .ch_cnt(ch_cnt), .ch_halt(ch_halt)
);

// File: tb/tb_dual_timer.sv
module tb_dual_timer;
    localparam int PER = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    int applied = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    dual_timer dut (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
                    .wdata(wdata), .rdata(rdata), .irq(irq));

    always #(PER/2) clk = ~clk;

    // Driver: one-clock write
    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Driver: present an address and queue the expected read data
    task automatic rd(input logic [4:0] a, input logic [31:0] e, input string t);
        item_t it;
        @(negedge clk);
        addr = a;
        it.is_irq = 1'b0; it.exp = e; it.tag = t;
        q.push_back(it);
    endtask

    // Driver: queue the expected interrupt level
    task automatic chk_irq(input logic e, input string t);
        item_t it;
        @(negedge clk);
        it.is_irq = 1'b1; it.exp = {31'd0, e}; it.tag = t;
        q.push_back(it);
    endtask

    // Monitor: compare a quarter period after each queued item
    initial begin
        forever begin
            item_t it;
            logic [31:0] act;
            wait (q.size() != 0);
            #(PER/4);
            it = q.pop_front();
            act = it.is_irq ? {31'd0, irq} : rdata;
            applied++;
            if (act !== it.exp) begin
                miscompares++;
                $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        rd(5'h00, 32'h0, "R1 ctrl0"); rd(5'h04, 32'h0, "R1 reld0"); rd(5'h08, 32'h0, "R1 cnt0");
        rd(5'h10, 32'h0, "R1 ctrl1"); rd(5'h14, 32'h0, "R1 reld1"); rd(5'h18, 32'h0, "R1 cnt1");
        chk_irq(1'b0, "R1 irq");

        // R2 decode, R3 read-back
        wr(5'h04, 32'h1234_5678);
        rd(5'h04, 32'h1234_5678, "R2 reld0");
        rd(5'h14, 32'h0, "R2 reld1 untouched");
        wr(5'h0C, 32'hFFFF_FFFF); wr(5'h06, 32'hFFFF_FFFF);
        rd(5'h0C, 32'h0, "R2 hole 0x0C"); rd(5'h1C, 32'h0, "R2 hole 0x1C");
        rd(5'h06, 32'h0, "R2 misaligned"); rd(5'h04, 32'h1234_5678, "R2 misaligned write ignored");
        wr(5'h10, 32'h0000_0001);
        rd(5'h10, 32'h1, "R3 mode bit");
        wr(5'h10, 32'hFFFF_F61D);
        rd(5'h10, 32'h0000_061D, "R3 fields");
        wr(5'h10, 32'h0);

        // R4 preset
        wr(5'h00, 32'h20);
        rd(5'h08, 32'h1234_5678, "R4 preset copies");
        wr(5'h04, 32'h100);
        rd(5'h08, 32'h100, "R4 preset follows new reload");
        wr(5'h00, 32'hA0);
        rd(5'h08, 32'h100, "R4 no count while preset");
        rd(5'h08, 32'h100, "R4 still held");

        // R5 up count, R7 stop
        wr(5'h00, 32'h80);
        rd(5'h08, 32'h101, "R5 up 1");
        rd(5'h08, 32'h102, "R5 up 2");
        wr(5'h00, 32'h00);
        rd(5'h08, 32'h104, "R7 frozen");
        rd(5'h08, 32'h104, "R7 frozen again");

        // R6 down count
        wr(5'h00, 32'h20);
        wr(5'h00, 32'h82);
        rd(5'h08, 32'hFF, "R6 down 1");
        wr(5'h00, 32'h00);
        rd(5'h08, 32'hFD, "R6 down then stop");

        // R8 down auto-reload on channel 1, R10, R11
        wr(5'h14, 32'd2);
        wr(5'h10, 32'h20);
        wr(5'h10, 32'h92);
        rd(5'h18, 32'd1, "R8 down 1");
        rd(5'h18, 32'd0, "R8 down 0");
        rd(5'h18, 32'd2, "R8 reloaded");
        rd(5'h10, 32'h192, "R10 pending set with ie off");
        chk_irq(1'b0, "R10 irq gated");
        wr(5'h10, 32'h12);
        rd(5'h10, 32'h112, "R11 zero leaves pending");
        wr(5'h10, 32'h112);
        rd(5'h10, 32'h012, "R11 one clears pending");

        // R9 one-shot up on channel 0
        wr(5'h04, 32'hFFFF_FFFE);
        wr(5'h00, 32'h20);
        wr(5'h00, 32'hC0);
        rd(5'h08, 32'hFFFF_FFFF, "R9 at top");
        rd(5'h08, 32'hFFFF_FFFF, "R9 held at top");
        rd(5'h00, 32'h1C0, "R9 run stays set");
        chk_irq(1'b1, "R12 irq ch0");
        wr(5'h00, 32'h1C0);
        rd(5'h00, 32'h0C0, "R11 ack by write-back");
        chk_irq(1'b0, "R12 irq dropped");

        // R12 channel 1 alone
        wr(5'h14, 32'd0);
        wr(5'h10, 32'h20);
        wr(5'h10, 32'hC2);
        chk_irq(1'b1, "R12 irq ch1");
        rd(5'h10, 32'h1C2, "R12 ch1 pending");
        rd(5'h00, 32'h0C0, "R12 ch0 unaffected");
        rd(5'h08, 32'hFFFF_FFFF, "R12 ch0 count unaffected");

        // R8 up auto-reload on channel 0
        wr(5'h04, 32'hFFFF_FFFD);
        wr(5'h00, 32'h20);
        wr(5'h00, 32'h90);
        rd(5'h08, 32'hFFFF_FFFE, "R8 up 1");
        rd(5'h08, 32'hFFFF_FFFF, "R8 up top");
        rd(5'h08, 32'hFFFF_FFFD, "R8 up reloaded");
        rd(5'h00, 32'h190, "R10 pending after up rollover");

        wait (q.size() == 0);
        @(negedge clk);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
        $finish;
    end
endmodule